// File: doc/BRIEF.md
# Weighted Penalty Distance Accumulator

This block scores how far a query vector lies from a stored template vector. Elements arrive one per clock cycle. Each element produces the signed difference between the template value and the query value. The magnitude of that difference is multiplied by a per-element weight. A two-bit per-element policy code then decides, using the sign of the difference, whether that weighted magnitude is added, subtracted or dropped. A per-element enable bit can exclude an element from the score altogether. This lets one sum express plain Manhattan distance, "lower is better" or "higher is better" one-sided penalties, and attributes that are ignored.

A single datapath is time-shared across a fixed number of templates. A start strobe marks the first element of each template and a last strobe marks its final element. The vector length is therefore set at run time, up to a maximum. When a template is finished, the block presents its score and a template index that steps through the templates in turn, together with a one-cycle valid indication. The template store, the preparation of the weights and the search for the best score are handled by neighbouring blocks.

Top module: `penalty_dist_acc`

## Requirements
- R1: After reset, `valid_o` is 0, `dist_o` is 0 and `idx_o` is 0.
- R2: For every element, D is |template − query| × weight. Policy code 0 adds +D for any ordering of query and template.
- R3: Policy code 1 adds +D only when the query is greater than the template, and adds 0 otherwise.
- R4: Policy code 2 adds −D only when the query is less than the template, and adds 0 otherwise.
- R5: Policy code 3 always adds 0. Equal query and template values add 0 under every policy code.
- R6: An element whose enable bit `en_i` is 0 adds 0, whatever its other fields hold.
- R7: An element that has `start_i` = 1 opens a new frame whose sum starts at zero. This holds even when a frame is already open; the abandoned frame produces no result.
- R8: `valid_o` is 1 in exactly the cycle after the clock edge that accepts a frame's closing element, with `dist_o` holding that frame's sum. In every other cycle `valid_o` is 0.
- R9: `idx_o` is 0 for the first result after reset. It increases by one with each further result and returns to 0 after NUM_TPL − 1.
- R10: The MAX_DIM-th element of a frame closes the frame even when `last_i` is 0.
- R11: The running sum saturates after each element at the signed limits of the ACC_W-bit accumulator, +(2^(ACC_W−1) − 1) and −2^(ACC_W−1). Later elements continue from the clamped value.
- R12: An element that arrives while no frame is open and that has `start_i` = 0 is ignored. It produces no result and does not affect the next frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Current element is the first of a template |
| last_i | input | 1 | Current element is the final one of a template |
| query_i | input | ELEM_W | Query element, unsigned |
| tmpl_i | input | ELEM_W | Template element, unsigned |
| weight_i | input | WGT_W | Element weight, unsigned |
| op_i | input | 2 | Policy code: 0 both sides, 1 query-above only, 2 query-below negated, 3 none |
| en_i | input | 1 | Element enable; 0 removes the element from the sum |
| dist_o | output | ACC_W | Signed accumulated distance of the finished template |
| idx_o | output | max(1, clog2(NUM_TPL)) | Template index of the result |
| valid_o | output | 1 | One-cycle result strobe |

## Verification
The assertions check the per-element contribution rules on every cycle: the sign and zero cases for each policy code, the enable bit and equal operands. They also check that a result strobe follows each frame closure and nothing else, and that the index stays in range and is captured at the closing element. Only the bench scenarios can show the numeric value of the sums, because the assertions do not compute products. The same holds for the clearing at a start that arrives mid-frame, stepwise saturation and recovery, closing on the maximum dimension, and the ignoring of stray elements outside a frame. The bench covers these with an exhaustive sweep of single-element frames over a reduced configuration, followed by directed multi-element frames.

// File: rtl/pda_pkg.sv
package pda_pkg;

    // Per-element policy codes
    typedef enum logic [1:0] {
        POL_BOTH  = 2'd0,   // +D for any ordering
        POL_ABOVE = 2'd1,   // +D only if query > template
        POL_BELOW = 2'd2,   // -D only if query < template
        POL_NONE  = 2'd3    // no contribution
    } pen_pol_e;

endpackage

// File: rtl/pda_elem.sv
module pda_elem
    import pda_pkg::*;
#(
    parameter int ELEM_W = 8,
    parameter int WGT_W  = 7,
    parameter int CON_W  = ELEM_W + WGT_W + 1
) (
    input  logic [ELEM_W-1:0]       query,
    input  logic [ELEM_W-1:0]       tmpl,
    input  logic [WGT_W-1:0]        weight,
    input  pen_pol_e                pol,
    input  logic                    en,
    output logic signed [CON_W-1:0] contrib
);
    localparam int PROD_W = ELEM_W + WGT_W;

    logic [ELEM_W:0]   diff;
    logic              borrow;      // 1 when query exceeds template
    logic [ELEM_W-1:0] mag;
    logic [PROD_W-1:0] prod;
    logic [CON_W-1:0]  pos_val;

    always_comb begin
        diff    = {1'b0, tmpl} - {1'b0, query};
        borrow  = diff[ELEM_W];
        // conditional invert plus increment gives the magnitude
        mag     = (diff[ELEM_W-1:0] ^ {ELEM_W{borrow}}) + {{(ELEM_W-1){1'b0}}, borrow};
        prod    = PROD_W'(mag) * PROD_W'(weight);
        pos_val = {1'b0, prod};
        contrib = '0;
        if (en) begin
            unique case (pol)
                POL_BOTH:  contrib = pos_val;
                POL_ABOVE: contrib = borrow ? pos_val : '0;
                POL_BELOW: contrib = borrow ? '0 : -pos_val;
                default:   contrib = '0;
            endcase
        end
    end

endmodule

// File: rtl/pda_seq.sv
module pda_seq #(
    parameter int MAX_DIM = 128,
    parameter int NUM_TPL = 10,
    parameter int IDX_W   = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             last,
    output logic             accept,
    output logic             first,
    output logic             close,
    output logic [IDX_W-1:0] tpl_idx
);
    localparam int CNT_W = $clog2(MAX_DIM + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_DIM - 1);
    localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(NUM_TPL - 1);

    typedef struct packed {
        logic             busy;
        logic [CNT_W-1:0] cnt;
        logic [IDX_W-1:0] idx;
    } seq_t;

    seq_t s_d, s_q;
    logic [CNT_W-1:0] cnt_cur;

    always_comb begin
        s_d     = s_q;
        accept  = start | s_q.busy;
        first   = start;
        cnt_cur = start ? '0 : s_q.cnt;
        close   = accept & (last | (cnt_cur == CNT_LAST));
        if (accept) begin
            if (close) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
                s_d.idx  = (s_q.idx == IDX_TOP) ? '0 : s_q.idx + 1'b1;
            end else begin
                s_d.busy = 1'b1;
                s_d.cnt  = cnt_cur + 1'b1;
            end
        end
        tpl_idx = s_q.idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/pda_accum.sv
module pda_accum #(
    parameter int ACC_W = 22,
    parameter int CON_W = 16,
    parameter int IDX_W = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    accept,
    input  logic                    first,
    input  logic                    close,
    input  logic signed [CON_W-1:0] contrib,
    input  logic [IDX_W-1:0]        tpl_idx,
    output logic [ACC_W-1:0]        res_dist,
    output logic [IDX_W-1:0]        res_idx,
    output logic                    res_vld
);
    localparam logic [ACC_W-1:0] SAT_HI = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] SAT_LO = {1'b1, {(ACC_W-1){1'b0}}};

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] res;
        logic [IDX_W-1:0] ridx;
        logic             vld;
    } acc_t;

    acc_t a_d, a_q;
    logic [ACC_W-1:0] base;
    logic [ACC_W:0]   wide;
    logic [ACC_W-1:0] sat;

    always_comb begin
        a_d     = a_q;
        a_d.vld = 1'b0;
        base    = first ? '0 : a_q.acc;
        wide    = {base[ACC_W-1], base}
                + {{(ACC_W+1-CON_W){contrib[CON_W-1]}}, contrib};
        // two top bits disagree: the sum left the ACC_W range
        if (wide[ACC_W] != wide[ACC_W-1]) sat = wide[ACC_W] ? SAT_LO : SAT_HI;
        else                              sat = wide[ACC_W-1:0];
        if (accept) begin
            if (close) begin
                a_d.res  = sat;
                a_d.ridx = tpl_idx;
                a_d.vld  = 1'b1;
                a_d.acc  = '0;
            end else begin
                a_d.acc  = sat;
            end
        end
        res_dist = a_q.res;
        res_idx  = a_q.ridx;
        res_vld  = a_q.vld;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) a_q <= '0;
        else        a_q <= a_d;
    end

endmodule

// File: rtl/penalty_dist_acc.sv
module penalty_dist_acc
    import pda_pkg::*;
#(
    parameter int ELEM_W  = 8,
    parameter int WGT_W   = 7,
    parameter int ACC_W   = 22,
    parameter int NUM_TPL = 10,
    parameter int MAX_DIM = 128,
    localparam int IDX_W  = (NUM_TPL > 1) ? $clog2(NUM_TPL) : 1,
    localparam int CON_W  = ELEM_W + WGT_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              last_i,
    input  logic [ELEM_W-1:0] query_i,
    input  logic [ELEM_W-1:0] tmpl_i,
    input  logic [WGT_W-1:0]  weight_i,
    input  logic [1:0]        op_i,
    input  logic              en_i,
    output logic [ACC_W-1:0]  dist_o,
    output logic [IDX_W-1:0]  idx_o,
    output logic              valid_o
);
    logic                    accept;
    logic                    first;
    logic                    close;
    logic [IDX_W-1:0]        tpl_idx;
    logic signed [CON_W-1:0] contrib;

    pda_elem #(
        .ELEM_W(ELEM_W), .WGT_W(WGT_W), .CON_W(CON_W)
    ) u_elem (
        .query  (query_i),
        .tmpl   (tmpl_i),
        .weight (weight_i),
        .pol    (pen_pol_e'(op_i)),
        .en     (en_i),
        .contrib(contrib)
    );

    pda_seq #(
        .MAX_DIM(MAX_DIM), .NUM_TPL(NUM_TPL), .IDX_W(IDX_W)
    ) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (start_i),
        .last   (last_i),
        .accept (accept),
        .first  (first),
        .close  (close),
        .tpl_idx(tpl_idx)
    );

    pda_accum #(
        .ACC_W(ACC_W), .CON_W(CON_W), .IDX_W(IDX_W)
    ) u_acc (
        .clk     (clk),
        .rst_n   (rst_n),
        .accept  (accept),
        .first   (first),
        .close   (close),
        .contrib (contrib),
        .tpl_idx (tpl_idx),
        .res_dist(dist_o),
        .res_idx (idx_o),
        .res_vld (valid_o)
    );

endmodule

// File: rtl/pda_checker.sv
module pda_checker #(
    parameter int ELEM_W  = 8,
    parameter int NUM_TPL = 10,
    parameter int IDX_W   = 4,
    parameter int CON_W   = 16
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic [ELEM_W-1:0]       query,
    input logic [ELEM_W-1:0]       tmpl,
    input logic [1:0]              op,
    input logic                    en,
    input logic signed [CON_W-1:0] contrib,
    input logic                    close,
    input logic [IDX_W-1:0]        tpl_idx,
    input logic [IDX_W-1:0]        idx_o,
    input logic                    valid
);
    localparam logic [IDX_W:0] TPL_LIM = (IDX_W+1)'(NUM_TPL);

    p_both_nonneg_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en && op == 2'd0) |-> !contrib[CON_W-1]);

    p_above_sided_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd1 && query <= tmpl) |-> contrib == '0);

    p_above_nonneg_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd1) |-> !contrib[CON_W-1]);

    p_below_sided_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd2 && query >= tmpl) |-> contrib == '0);

    p_below_nonpos_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd2) |-> (contrib == '0 || contrib[CON_W-1]));

    p_none_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 2'd3) |-> contrib == '0);

    p_equal_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (query == tmpl) |-> contrib == '0);

    p_masked_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !en |-> contrib == '0);

    p_valid_after_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> valid);

    p_valid_only_close_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !close |=> !valid);

    p_idx_captured_r9: assert property (@(posedge clk) disable iff (!rst_n)
        close |=> idx_o == $past(tpl_idx));

    p_idx_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> {1'b0, idx_o} < TPL_LIM);

endmodule

bind penalty_dist_acc pda_checker #(
    .ELEM_W(ELEM_W), .NUM_TPL(NUM_TPL), .IDX_W(IDX_W), .CON_W(CON_W)
) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .query  (query_i),
    .tmpl   (tmpl_i),
    .op     (op_i),
    .en     (en_i),
    .contrib(contrib),
    .close  (close),
    .tpl_idx(tpl_idx),
    .idx_o  (idx_o),
    .valid  (valid_o)
);

// File: tb/penalty_dist_acc_test.sv
module penalty_dist_acc_test;
    localparam int EW = 4;
    localparam int WW = 3;
    localparam int AW = 9;
    localparam int NT = 3;
    localparam int MD = 4;
    localparam int IW = 2;
    localparam int SMAX = 255;
    localparam int SMIN = -256;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0, last_i = 1'b0, en_i = 1'b0;
    logic [EW-1:0] query_i = '0, tmpl_i = '0;
    logic [WW-1:0] weight_i = '0;
    logic [1:0]    op_i = '0;
    logic [AW-1:0] dist_o;
    logic [IW-1:0] idx_o;
    logic          valid_o;

    int checks = 0;
    int errors = 0;
    int exp_idx = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    penalty_dist_acc #(
        .ELEM_W(EW), .WGT_W(WW), .ACC_W(AW), .NUM_TPL(NT), .MAX_DIM(MD)
    ) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .last_i(last_i),
        .query_i(query_i), .tmpl_i(tmpl_i), .weight_i(weight_i),
        .op_i(op_i), .en_i(en_i), .dist_o(dist_o), .idx_o(idx_o),
        .valid_o(valid_o)
    );

    function automatic int contrib_of(int q, int t, int w, int op, int en);
        int d;
        if (en == 0) return 0;
        d = (t > q) ? (t - q) * w : (q - t) * w;
        case (op)
            0: return d;
            1: return (q > t) ? d : 0;
            2: return (q < t) ? -d : 0;
            default: return 0;
        endcase
    endfunction

    function automatic int clamp(int v);
        if (v > SMAX) return SMAX;
        if (v < SMIN) return SMIN;
        return v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic elem(input int q, input int t, input int w, input int op,
                        input int en, input int st, input int la);
        query_i  = EW'(q);
        tmpl_i   = EW'(t);
        weight_i = WW'(w);
        op_i     = 2'(op);
        en_i     = 1'(en);
        start_i  = 1'(st);
        last_i   = 1'(la);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic expect_result(input string req, input int value);
        check("R8 valid", int'(valid_o), 1);
        check(req, $signed(dist_o), value);
        check("R9 index", int'(idx_o), exp_idx);
        exp_idx = (exp_idx + 1) % NT;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int acc;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        check("R1 valid", int'(valid_o), 0);
        check("R1 dist", $signed(dist_o), 0);
        check("R1 idx", int'(idx_o), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R2..R6, R8, R9: exhaustive single-element frames
        for (int op = 0; op < 4; op++)
            for (int en = 0; en < 2; en++)
                for (int q = 0; q < 16; q++)
                    for (int t = 0; t < 16; t++)
                        for (int w = 0; w < 8; w++) begin
                            string tag;
                            elem(q, t, w, op, en, 1, 1);
                            if (en == 0)     tag = "R6 masked";
                            else if (q == t) tag = "R5 equal";
                            else if (op == 0) tag = "R2 both";
                            else if (op == 1) tag = "R3 above";
                            else if (op == 2) tag = "R4 below";
                            else             tag = "R5 none";
                            expect_result(tag, contrib_of(q, t, w, op, en));
                        end

        // R8: strobe is one cycle wide
        elem(0, 0, 0, 0, 0, 0, 0);
        check("R8 pulse", int'(valid_o), 0);

        // R8: mixed three-element frame, no strobe mid-frame
        elem(5, 2, 3, 0, 1, 1, 0);
        check("R8 mid", int'(valid_o), 0);
        elem(1, 7, 2, 2, 1, 0, 0);
        check("R8 mid", int'(valid_o), 0);
        elem(9, 4, 1, 1, 1, 0, 1);
        expect_result("R8 sum", 9 - 12 + 5);

        // R7: start while open restarts from zero
        elem(0, 7, 7, 0, 1, 1, 0);
        elem(3, 1, 1, 0, 1, 1, 0);
        check("R7 no result", int'(valid_o), 0);
        elem(2, 2, 5, 0, 1, 0, 1);
        expect_result("R7 restart", 2);

        // R10 + R11: four elements without last close and saturate high
        for (int i = 0; i < MD; i++) begin
            elem(0, 15, 7, 0, 1, (i == 0) ? 1 : 0, 0);
            if (i < MD - 1) check("R10 open", int'(valid_o), 0);
        end
        expect_result("R11 sat high", SMAX);

        // R12: stray element outside a frame is ignored
        elem(0, 15, 7, 0, 1, 0, 1);
        check("R12 ignored", int'(valid_o), 0);
        elem(1, 0, 1, 0, 1, 1, 1);
        expect_result("R12 clean", 1);

        // R11: saturate low
        for (int i = 0; i < 4; i++)
            elem(0, 15, 7, 2, 1, (i == 0) ? 1 : 0, (i == 3) ? 1 : 0);
        expect_result("R11 sat low", SMIN);

        // R11: stepwise clamp then recovery
        acc = 0;
        for (int i = 0; i < 4; i++) begin
            int op = (i == 3) ? 2 : 0;
            acc = clamp(acc + contrib_of(0, 15, 7, op, 1));
            elem(0, 15, 7, op, 1, (i == 0) ? 1 : 0, (i == 3) ? 1 : 0);
        end
        expect_result("R11 recover", acc);

        elem(0, 0, 0, 0, 0, 0, 0);
        check("R8 idle", int'(valid_o), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule